// File: doc/BRIEF.md
# Byte-Wide Multiplexed Register Port

This block is a slave port that gives an external controller access to an internal register file over one 8-bit bus. The bus carries the address and then the data. A port clock, an active-low select and a read/write line control it. Each access moves exactly one byte and takes three port-clock cycles:

1. The address cycle latches the address byte.
2. The data cycle drives the read byte or takes the write byte.
3. The recovery cycle returns the port to rest.

Registers wider than a byte are reached one byte address at a time. The port never increments the address and has no burst mode.

The register file itself lives outside the block. The port presents the latched address and a one-cycle write strobe with the write byte. For reads, it takes the read byte back combinationally. Addresses at or above `NUM_REGS` are unmapped: reads of them return zero and writes to them produce no strobe. The port drives the shared bus only while it returns read data. If the select is raised in the middle of an access, the access is abandoned at once.

Top module: `bytebus_port`

## Requirements
- R1: While reset is held, `bus_oe` and `reg_we` are 0 and `reg_addr` is 0x00, whatever the bus inputs are.
- R2: With the port idle and `sel_n` low, the byte on `bus_in` is latched at the clock edge and shows on `reg_addr` during the following data cycle.
- R3: In the data cycle of a read (`rd_wr` = 1 at the address cycle), `bus_oe` is 1 and `bus_out` carries `reg_rdata` for the latched address.
- R4: `bus_oe` is 0 during the address cycle, the recovery cycle, every cycle of a write, and whenever the port is idle.
- R5: In the data cycle of a write (`rd_wr` = 0) to a mapped address, `reg_we` is 1 for exactly that one cycle and `reg_wdata` equals `bus_in`.
- R6: An access lasts three cycles. The recovery cycle never starts a new access: a byte presented there with `sel_n` low is not latched as an address, and the next address is taken only in the cycle after recovery.
- R7: If `sel_n` is high during the data cycle, no write strobe is issued, the bus is not driven, and the next access starts normally from idle.
- R8: For an address of `NUM_REGS` (default 20, i.e. 0x14) or more, a read returns 0x00 on `bus_out` and a write produces no `reg_we` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select; high aborts an access |
| rd_wr | input | 1 | 1 = read, 0 = write, sampled in the address cycle |
| bus_in | input | 8 | Incoming side of the shared address/data bus |
| bus_out | output | 8 | Outgoing side of the shared bus (read data) |
| bus_oe | output | 1 | Bus drive enable for the outgoing side |
| reg_addr | output | 8 | Latched register address |
| reg_wdata | output | 8 | Write byte to the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read byte from the register file at `reg_addr` |

## Verification
The assertions assume that `sel_n`, `rd_wr` and `bus_in` are synchronous to the port clock and settled before each rising edge. They also assume that an abort is signalled only through `sel_n`. The bench changes every input on the falling edge. It samples the outputs one nanosecond later, midway through the cycle in which the state has just advanced. Back-to-back accesses are driven with `sel_n` held low, so the recovery rule is exercised without the select toggling.

// File: rtl/bytebus_port.sv
module bytebus_port #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_wr,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);

  typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_RECOV} phase_t;

  phase_t phase;
  logic   is_read;
  logic   mapped;

  assign mapped = (32'(reg_addr) < NUM_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_ADDR;
      is_read  <= 1'b0;
      reg_addr <= '0;
    end else if (sel_n) begin
      phase <= PH_ADDR;
    end else begin
      unique case (phase)
        PH_ADDR: begin
          reg_addr <= bus_in;
          is_read  <= rd_wr;
          phase    <= PH_DATA;
        end
        PH_DATA:  phase <= PH_RECOV;
        default:  phase <= PH_ADDR;
      endcase
    end
  end

  assign bus_oe    = (phase == PH_DATA) && is_read && !sel_n;
  assign bus_out   = (bus_oe && mapped) ? reg_rdata : '0;
  assign reg_we    = (phase == PH_DATA) && !is_read && !sel_n && mapped;
  assign reg_wdata = bus_in;

endmodule

// File: rtl/bytebus_port_chk.sv
module bytebus_port_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              bus_oe,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_addr
);

  a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r4_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && reg_we));

  a_r7_released_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (!bus_oe && !reg_we));

  a_r8_strobe_only_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (32'(reg_addr) < NUM_REGS));

  a_r6_drive_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |=> !bus_oe);

endmodule

bind bytebus_port bytebus_port_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .bus_oe(bus_oe),
  .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/bytebus_port_test.sv
module bytebus_port_test;
  localparam int NR = 20;

  logic       clk = 0, rst_n = 0, sel_n = 1, rd_wr = 0;
  logic [7:0] bus_in = 0, bus_out, reg_addr, reg_wdata, reg_rdata;
  logic       bus_oe, reg_we;
  logic [7:0] mem [256];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bytebus_port #(.DATA_W(8), .NUM_REGS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  // {rd_wr, addr, data, expected read byte}
  localparam logic [24:0] TBL [10] = '{
    {1'b0, 8'h03, 8'hA5, 8'h00},
    {1'b0, 8'h13, 8'h3C, 8'h00},
    {1'b0, 8'h14, 8'hFF, 8'h00},
    {1'b1, 8'h03, 8'h00, 8'hA5},
    {1'b1, 8'h13, 8'h00, 8'h3C},
    {1'b1, 8'h14, 8'h00, 8'h00},
    {1'b1, 8'hFF, 8'h00, 8'h00},
    {1'b0, 8'h00, 8'h11, 8'h00},
    {1'b1, 8'h00, 8'h00, 8'h11},
    {1'b1, 8'h0A, 8'h00, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic rw, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] e, input bit abort);
    @(negedge clk); sel_n = 0; rd_wr = rw; bus_in = a; #1;
    chk(!bus_oe, "R4 address cycle", {7'b0, bus_oe}, 8'h00);
    @(negedge clk); bus_in = d; if (abort) sel_n = 1; #1;
    chk(reg_addr == a, "R2 latched address", reg_addr, a);
    if (abort) begin
      chk(!bus_oe && !reg_we, "R7 abort", {6'b0, bus_oe, reg_we}, 8'h00);
    end else if (rw) begin
      chk(bus_oe, "R3 drive enable", {7'b0, bus_oe}, 8'h01);
      chk(bus_out == e, (a < NR) ? "R3 read byte" : "R8 unmapped read", bus_out, e);
    end else begin
      chk(!bus_oe, "R4 write cycle", {7'b0, bus_oe}, 8'h00);
      chk(reg_we == (a < NR), (a < NR) ? "R5 strobe" : "R8 unmapped write",
          {7'b0, reg_we}, {7'b0, a < NR});
      if (a < NR) chk(reg_wdata == d, "R5 write byte", reg_wdata, d);
    end
    @(negedge clk); #1;
    chk(!bus_oe && !reg_we, "R4 recovery", {6'b0, bus_oe, reg_we}, 8'h00);
    sel_n = 1;
  endtask

  initial begin
    foreach (mem[i]) mem[i] = 8'h00;
    mem[8'h14] = 8'h77;
    mem[8'hFF] = 8'h66;
    sel_n = 0; rd_wr = 1; bus_in = 8'h42;
    repeat (3) @(negedge clk);
    chk(!bus_oe && !reg_we && reg_addr == 0, "R1 reset state", reg_addr, 8'h00);
    sel_n = 1; rst_n = 1;

    foreach (TBL[i]) access(TBL[i][24], TBL[i][23:16], TBL[i][15:8], TBL[i][7:0], 0);

    // R6: back-to-back with select held low
    @(negedge clk); sel_n = 0; rd_wr = 0; bus_in = 8'h05;
    @(negedge clk); bus_in = 8'h5A; #1;
    chk(reg_we && reg_wdata == 8'h5A, "R5 back-to-back write", reg_wdata, 8'h5A);
    @(negedge clk); rd_wr = 1; bus_in = 8'h02; #1;
    chk(!bus_oe, "R4 recovery held select", {7'b0, bus_oe}, 8'h00);
    @(negedge clk); #1;
    chk(reg_addr == 8'h05 && !bus_oe, "R6 recovery not latched", reg_addr, 8'h05);
    bus_in = 8'h05;
    @(negedge clk); #1;
    chk(reg_addr == 8'h05 && bus_oe && bus_out == 8'h5A, "R6 next access read", bus_out, 8'h5A);
    @(negedge clk); sel_n = 1;

    // R7: aborted write leaves register untouched, next access normal
    access(0, 8'h03, 8'hEE, 8'h00, 1);
    access(1, 8'h03, 8'h00, 8'hA5, 0);
    access(1, 8'h03, 8'h00, 8'hA5, 1);
    access(1, 8'h13, 8'h00, 8'h3C, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule